// File: doc/BRIEF.md
# Time-of-Day Control State Machine

Each chip has one of these controllers. It follows the life cycle of the chip's time-of-day clock through four states: error, not-set, stopped and running. Software drives it over a 64-bit, word-addressed register bus. Writes to command offsets load the clock, arm it or start it, and writes to two broadcast offsets send synchronisation commands toward the peer chips. The controller also accepts the same two commands from its peers. Each command is legal only in certain states. A command given in any other state leaves the state as it was and sets a sticky bit in an error register, which software clears by writing ones.

Bit positions in this brief use MSB-0 numbering: bit n of a 64-bit word is bit 63-n in LSB-0 terms. The state encoding is sparse and is visible on the `todState` port: error = 0, stopped = 1, running = 2, not-set = 7. The status word is not stored. It is built at read time from the current state and the two role straps. A read returns its data one cycle after the request.

Top module: `tod_state_ctrl`

## Requirements
- R1: While reset is held and right after it, the state is error (0) and no output pulses. The error register reads zero. The master/slave control register reads with bit 1 equal to the primary strap, bit 2 set and every other bit clear.
- R2: A write to offset 0x18 with bit 0 set moves the machine to not-set (7) from any state. If bit 0 is clear, the state is kept and error bit 0 is set.
- R3: A write to offset 0x21 is honoured only in not-set. It moves the machine to stopped (1) when bit 63 of the data is set and to running (2) when it is clear. In any other state the state is kept and error bit 1 is set.
- R4: A write to offset 0x22 moves stopped to running. In any other state the state is kept and error bit 2 is set.
- R5: A peer invalidate pulse forces not-set from any state. A peer send-time pulse moves not-set to running. In any other state it keeps the state and sets error bit 3. When both arrive together, the invalidate wins.
- R6: A write to offset 0x15 gives a one-cycle `bcastSendTime` pulse and a write to offset 0x16 gives a one-cycle `bcastInvalidate` pulse, both in the cycle after the write. Neither write changes the local state.
- R7: A read of offset 0x08 returns bits 6–10, 12, 21 and 26 set, and bit 20 set only when running. It also sets exactly one role bit: bit 23 if the primary strap is high, otherwise bit 24 if the secondary strap is high, otherwise bit 25. All other bits are zero.
- R8: A write to offset 0x07 stores bits 0–31 of the data and clears bits 32–63. Bit 1 is replaced by the primary strap and bit 2 is forced to one. A read of 0x07 returns the stored word.
- R9: A read of offset 0x24 returns bit 4 set when running and zero otherwise.
- R10: Error bits 0–4 sit at bits 0–4 of offset 0x30. A write to 0x30 clears every error bit whose data bit is one. A bit that is set by an event in the same cycle stays set.
- R11: A read or write of any offset not listed for that direction gives a one-cycle `unimplAccess` pulse in the next cycle and sets error bit 4. Such a read returns zero. Readable offsets: 0x07, 0x08, 0x24, 0x30. Writable offsets: 0x07, 0x15, 0x16, 0x18, 0x21, 0x22, 0x30.
- R12: In a cycle with a peer pulse, a local bus state command (0x18, 0x21, 0x22) is dropped. It changes no state and sets no error bit.
- R13: A read request gives `busRdValid` high for exactly the next cycle, with data taken from the state before that cycle's updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write request |
| busRdEn | input | 1 | Read request |
| busAddr | input | ADDR_W (6) | Word offset |
| busWrData | input | 64 | Write data, MSB-0 bit numbering |
| busRdData | output | 64 | Read data, valid with busRdValid |
| busRdValid | output | 1 | Read data valid, one cycle after busRdEn |
| strapPrimary | input | 1 | Chip is the primary master |
| strapSecondary | input | 1 | Chip is the backup master |
| peerSendTime | input | 1 | Send-time command received from a peer |
| peerInvalidate | input | 1 | Invalidate command received from a peer |
| bcastSendTime | output | 1 | Send-time pulse toward the peers |
| bcastInvalidate | output | 1 | Invalidate pulse toward the peers |
| todState | output | 3 | Current state code |
| unimplAccess | output | 1 | Pulse after an access to an unimplemented offset |

## Verification
The assertions take peer pulses, bus reads and bus writes to be single-cycle strobes that share one address in a cycle. They also take the straps to be steady while a status read is in flight. The stimulus drives every input on the falling clock edge and holds it for one whole cycle. It changes straps only between transactions. It deliberately overlaps peer pulses with bus commands and error-register clears, so that the precedence rules are exercised rather than avoided.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int DATA_W = 64;
  localparam int ERR_W  = 5;

  localparam int OFF_CTRL   = 'h07;
  localparam int OFF_STATUS = 'h08;
  localparam int OFF_TX4    = 'h15;
  localparam int OFF_TX5    = 'h16;
  localparam int OFF_LDMOD  = 'h18;
  localparam int OFF_LOAD   = 'h21;
  localparam int OFF_START  = 'h22;
  localparam int OFF_FSM    = 'h24;
  localparam int OFF_ERR    = 'h30;

  localparam int ERR_MOD    = 0;
  localparam int ERR_LOAD   = 1;
  localparam int ERR_START  = 2;
  localparam int ERR_RXSEND = 3;
  localparam int ERR_UNIMPL = 4;

  typedef enum logic [2:0] {
    TOD_ERROR   = 3'd0,
    TOD_STOPPED = 3'd1,
    TOD_RUNNING = 3'd2,
    TOD_NOTSET  = 3'd7
  } todState_e;

  typedef enum logic [2:0] {
    RD_NONE, RD_CTRL, RD_STATUS, RD_FSM, RD_ERR
  } rdSel_e;

  typedef struct packed {
    logic             ctrlWr;
    logic             errClr;
    logic [ERR_W-1:0] errSet;
    logic             txSend;
    logic             txInval;
    logic             rdReq;
    rdSel_e           rdSel;
    logic             unimpl;
  } todStrobe_t;

  // LSB-0 index of an MSB-0 bit number
  function automatic int msb0(input int n);
    return DATA_W - 1 - n;
  endfunction
endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              armBit,
  input  logic              stopBit,
  input  logic              rxSendTime,
  input  logic              rxInvalidate,
  output todState_e         state,
  output todStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_TX4    = ADDR_W'(OFF_TX4);
  localparam logic [ADDR_W-1:0] A_TX5    = ADDR_W'(OFF_TX5);
  localparam logic [ADDR_W-1:0] A_LDMOD  = ADDR_W'(OFF_LDMOD);
  localparam logic [ADDR_W-1:0] A_LOAD   = ADDR_W'(OFF_LOAD);
  localparam logic [ADDR_W-1:0] A_START  = ADDR_W'(OFF_START);
  localparam logic [ADDR_W-1:0] A_FSM    = ADDR_W'(OFF_FSM);
  localparam logic [ADDR_W-1:0] A_ERR    = ADDR_W'(OFF_ERR);

  todState_e        stateQ, stateNxt, busNxt;
  logic [ERR_W-1:0] busErr;
  logic             wrUnimpl, rdUnimpl, rxAny;

  assign rxAny = rxSendTime | rxInvalidate;

  always_comb begin
    strb     = '0;
    strb.rdSel = RD_NONE;
    busNxt   = stateQ;
    busErr   = '0;
    wrUnimpl = 1'b0;
    rdUnimpl = 1'b0;
    if (wrEn) begin
      case (addr)
        A_CTRL:  strb.ctrlWr  = 1'b1;
        A_ERR:   strb.errClr  = 1'b1;
        A_TX4:   strb.txSend  = 1'b1;
        A_TX5:   strb.txInval = 1'b1;
        A_LDMOD: begin
          if (armBit) busNxt = TOD_NOTSET;
          else        busErr[ERR_MOD] = 1'b1;
        end
        A_LOAD: begin
          if (stateQ == TOD_NOTSET) busNxt = stopBit ? TOD_STOPPED : TOD_RUNNING;
          else                      busErr[ERR_LOAD] = 1'b1;
        end
        A_START: begin
          if (stateQ == TOD_STOPPED) busNxt = TOD_RUNNING;
          else                       busErr[ERR_START] = 1'b1;
        end
        default: wrUnimpl = 1'b1;
      endcase
    end
    if (rdEn) begin
      strb.rdReq = 1'b1;
      case (addr)
        A_CTRL:   strb.rdSel = RD_CTRL;
        A_STATUS: strb.rdSel = RD_STATUS;
        A_FSM:    strb.rdSel = RD_FSM;
        A_ERR:    strb.rdSel = RD_ERR;
        default:  rdUnimpl   = 1'b1;
      endcase
    end
    // peer commands take precedence; a local state command is dropped
    if (rxInvalidate) begin
      stateNxt = TOD_NOTSET;
    end else if (rxSendTime) begin
      if (stateQ == TOD_NOTSET) stateNxt = TOD_RUNNING;
      else begin
        stateNxt = stateQ;
        strb.errSet[ERR_RXSEND] = 1'b1;
      end
    end else begin
      stateNxt    = busNxt;
      strb.errSet = busErr;
    end
    strb.unimpl = wrUnimpl | rdUnimpl;
    strb.errSet[ERR_UNIMPL] = wrUnimpl | rdUnimpl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= TOD_ERROR;
    else       stateQ <= stateNxt;
  end

  assign state = stateQ;

  // R5: an invalidate from a peer always lands in not-set
  a_r5_inval_any_state: assert property (@(posedge clk) disable iff (!rstN)
    rxInvalidate |=> stateQ == TOD_NOTSET);

  // R3: a load outside not-set leaves the state alone
  a_r3_load_rejected: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_LOAD && stateQ != TOD_NOTSET && !rxAny) |=> $stable(stateQ));

  // R4: start from stopped always reaches running
  a_r4_start_runs: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_START && stateQ == TOD_STOPPED && !rxAny) |=> stateQ == TOD_RUNNING);

  // R6: broadcasting does not move the local state
  a_r6_bcast_keeps_state: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addr == A_TX4 || addr == A_TX5) && !rxAny) |=> $stable(stateQ));
endmodule

// File: rtl/tod_regs.sv
module tod_regs
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  todStrobe_t        strb,
  input  todState_e         state,
  input  logic [DATA_W-1:0] wrData,
  input  logic              strapPrimary,
  input  logic              strapSecondary,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              txSendTime,
  output logic              txInvalidate,
  output logic              unimplAccess
);
  logic [DATA_W-1:0] ctrlQ, rdDataQ, statusWord, fsmWord, errWord, rdMux;
  logic [ERR_W-1:0]  errQ, clrMask;
  logic              rdValidQ, txSendQ, txInvalQ, unimplQ;
  rdSel_e            rdSelQ;

  function automatic logic [DATA_W-1:0] forceCtrl(input logic [DATA_W-1:0] v,
                                                  input logic prim);
    logic [DATA_W-1:0] r;
    r = v;
    for (int i = 32; i < DATA_W; i++) r[msb0(i)] = 1'b0;
    r[msb0(1)] = prim;
    r[msb0(2)] = 1'b1;
    return r;
  endfunction

  // error field i sits at MSB-0 bit i
  always_comb begin
    errWord = '0;
    for (int i = 0; i < ERR_W; i++) begin
      errWord[msb0(i)] = errQ[i];
      clrMask[i]       = strb.errClr & wrData[msb0(i)];
    end
  end

  always_comb begin
    statusWord = '0;
    for (int b = 6; b <= 10; b++) statusWord[msb0(b)] = 1'b1;
    statusWord[msb0(12)] = 1'b1;
    statusWord[msb0(21)] = 1'b1;
    statusWord[msb0(26)] = 1'b1;
    statusWord[msb0(20)] = (state == TOD_RUNNING);
    if (strapPrimary)        statusWord[msb0(23)] = 1'b1;
    else if (strapSecondary) statusWord[msb0(24)] = 1'b1;
    else                     statusWord[msb0(25)] = 1'b1;
    fsmWord = '0;
    fsmWord[msb0(4)] = (state == TOD_RUNNING);
  end

  always_comb begin
    case (strb.rdSel)
      RD_CTRL:   rdMux = ctrlQ;
      RD_STATUS: rdMux = statusWord;
      RD_FSM:    rdMux = fsmWord;
      RD_ERR:    rdMux = errWord;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= forceCtrl('0, strapPrimary);
      errQ     <= '0;
      rdDataQ  <= '0;
      rdValidQ <= 1'b0;
      rdSelQ   <= RD_NONE;
      txSendQ  <= 1'b0;
      txInvalQ <= 1'b0;
      unimplQ  <= 1'b0;
    end else begin
      if (strb.ctrlWr) ctrlQ <= forceCtrl(wrData, strapPrimary);
      errQ     <= (errQ & ~clrMask) | strb.errSet;
      rdDataQ  <= strb.rdReq ? rdMux : '0;
      rdValidQ <= strb.rdReq;
      rdSelQ   <= strb.rdSel;
      txSendQ  <= strb.txSend;
      txInvalQ <= strb.txInval;
      unimplQ  <= strb.unimpl;
    end
  end

  assign rdData       = rdDataQ;
  assign rdValid      = rdValidQ;
  assign txSendTime   = txSendQ;
  assign txInvalidate = txInvalQ;
  assign unimplAccess = unimplQ;

  // R13: a read request is answered in the following cycle
  a_r13_read_valid: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdReq |=> rdValid);

  // R7: a status read carries exactly one role bit
  a_r7_one_role: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdSelQ == RD_STATUS) |-> $countones(rdData[msb0(23):msb0(25)]) == 1);

  // R8: the control register never shows its upper half
  a_r8_ctrl_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdSelQ == RD_CTRL) |-> (rdData[msb0(32):0] == '0 && rdData[msb0(2)]));

  // R6: at most one broadcast pulse at a time
  a_r6_bcast_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txSendTime, txInvalidate}));
endmodule

// File: rtl/tod_state_ctrl.sv
module tod_state_ctrl
  import tod_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [63:0]       busWrData,
  output logic [63:0]       busRdData,
  output logic              busRdValid,
  input  logic              strapPrimary,
  input  logic              strapSecondary,
  input  logic              peerSendTime,
  input  logic              peerInvalidate,
  output logic              bcastSendTime,
  output logic              bcastInvalidate,
  output logic [2:0]        todState,
  output logic              unimplAccess
);
  todState_e  state;
  todStrobe_t strb;

  tod_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (busWrEn),
    .rdEn        (busRdEn),
    .addr        (busAddr),
    .armBit      (busWrData[msb0(0)]),
    .stopBit     (busWrData[msb0(63)]),
    .rxSendTime  (peerSendTime),
    .rxInvalidate(peerInvalidate),
    .state       (state),
    .strb        (strb)
  );

  tod_regs u_regs (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .state         (state),
    .wrData        (busWrData),
    .strapPrimary  (strapPrimary),
    .strapSecondary(strapSecondary),
    .rdData        (busRdData),
    .rdValid       (busRdValid),
    .txSendTime    (bcastSendTime),
    .txInvalidate  (bcastInvalidate),
    .unimplAccess  (unimplAccess)
  );

  assign todState = state;
endmodule

// File: tb/tod_state_ctrl_tb.sv
module tod_state_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 0, busRdEn = 0;
  logic [5:0]  busAddr = '0;
  logic [63:0] busWrData = '0;
  logic [63:0] busRdData;
  logic        busRdValid;
  logic        strapPrimary = 1'b1, strapSecondary = 1'b0;
  logic        peerSendTime = 0, peerInvalidate = 0;
  logic        bcastSendTime, bcastInvalidate, unimplAccess;
  logic [2:0]  todState;

  int    checks = 0;
  int    errors = 0;
  string phase  = "R1";

  always #10 clk = ~clk;

  tod_state_ctrl u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .busRdValid(busRdValid), .strapPrimary(strapPrimary),
    .strapSecondary(strapSecondary), .peerSendTime(peerSendTime),
    .peerInvalidate(peerInvalidate), .bcastSendTime(bcastSendTime),
    .bcastInvalidate(bcastInvalidate), .todState(todState),
    .unimplAccess(unimplAccess)
  );

  function automatic logic [63:0] bit0n(input int n);
    return 64'd1 << (63 - n);
  endfunction

  // ---------------- reference model ----------------
  int          mState = 0;
  logic [4:0]  mErr = '0;
  logic [63:0] mCtrl = 64'h2000_0000_0000_0000;
  logic [63:0] eRd = '0;
  logic        eRdValid = 0, eTx4 = 0, eTx5 = 0, eUnimpl = 0;

  function automatic logic [63:0] ctrlVal(input logic [63:0] d, input logic p);
    logic [63:0] r;
    r = d & 64'hFFFF_FFFF_0000_0000;
    r = p ? (r | bit0n(1)) : (r & ~bit0n(1));
    return r | bit0n(2);
  endfunction

  function automatic logic [63:0] readModel(input logic [5:0] a, output bit bad);
    logic [63:0] v;
    bad = 0;
    v = '0;
    case (a)
      6'h07: v = mCtrl;
      6'h08: begin
        v = bit0n(6) | bit0n(7) | bit0n(8) | bit0n(9) | bit0n(10) |
            bit0n(12) | bit0n(21) | bit0n(26);
        if (mState == 2) v |= bit0n(20);
        v |= strapPrimary ? bit0n(23) : (strapSecondary ? bit0n(24) : bit0n(25));
      end
      6'h24: if (mState == 2) v = bit0n(4);
      6'h30: for (int i = 0; i < 5; i++) if (mErr[i]) v |= bit0n(i);
      default: bad = 1;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    logic [4:0] setB, clrB;
    int         busS;
    bit         rdBad, wrBad;
    if (!rstN) begin
      mState = 0; mErr = '0; mCtrl = ctrlVal('0, strapPrimary);
      eRd = '0; eRdValid = 0; eTx4 = 0; eTx5 = 0; eUnimpl = 0;
    end else begin
      setB = '0; clrB = '0; busS = mState; rdBad = 0; wrBad = 0;
      eRdValid = busRdEn;
      eRd = busRdEn ? readModel(busAddr, rdBad) : '0;
      eTx4 = busWrEn && busAddr == 6'h15;
      eTx5 = busWrEn && busAddr == 6'h16;
      if (busWrEn) begin
        case (busAddr)
          6'h07: mCtrl = ctrlVal(busWrData, strapPrimary);
          6'h30: for (int i = 0; i < 5; i++) clrB[i] = busWrData[63 - i];
          6'h15, 6'h16: ;
          6'h18: if (busWrData[63]) busS = 7; else setB[0] = 1;
          6'h21: if (mState == 7) busS = busWrData[0] ? 1 : 2; else setB[1] = 1;
          6'h22: if (mState == 1) busS = 2; else setB[2] = 1;
          default: wrBad = 1;
        endcase
      end
      if (peerInvalidate) begin
        mState = 7; setB = '0;
      end else if (peerSendTime) begin
        setB = '0;
        if (mState == 7) mState = 2; else setB[3] = 1;
      end else begin
        mState = busS;
      end
      eUnimpl = rdBad | wrBad;
      if (eUnimpl) setB[4] = 1;
      mErr = (mErr & ~clrB) | setB;
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      chk("state", 64'(todState), 64'(mState));
      chk("rdValid", 64'(busRdValid), 64'(eRdValid));
      chk("bcastSendTime", 64'(bcastSendTime), 64'(eTx4));
      chk("bcastInvalidate", 64'(bcastInvalidate), 64'(eTx5));
      chk("unimplAccess", 64'(unimplAccess), 64'(eUnimpl));
      if (eRdValid) chk("rdData", busRdData, eRd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input bit we, input bit re, input logic [5:0] a,
                     input logic [63:0] d, input bit rs, input bit ri);
    busWrEn = we; busRdEn = re; busAddr = a; busWrData = d;
    peerSendTime = rs; peerInvalidate = ri;
    @(negedge clk);
  endtask
  task automatic wr(input logic [5:0] a, input logic [63:0] d);
    cyc(1, 0, a, d, 0, 0);
  endtask
  task automatic rd(input logic [5:0] a);
    cyc(0, 1, a, '0, 0, 0);
  endtask
  task automatic idle();
    cyc(0, 0, '0, '0, 0, 0);
  endtask

  localparam logic [63:0] ARM  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] STOP = 64'h0000_0000_0000_0001;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    phase = "R1"; idle(); rd(6'h07); rd(6'h30); rd(6'h24); idle();
    phase = "R4"; wr(6'h22, '0); rd(6'h30);
    phase = "R3"; wr(6'h21, '0); rd(6'h30);
    phase = "R2"; wr(6'h18, 64'h1); rd(6'h30); wr(6'h18, ARM); rd(6'h24);
    phase = "R10"; wr(6'h30, ARM); rd(6'h30); wr(6'h30, 64'hF800_0000_0000_0000); rd(6'h30);
    phase = "R3"; wr(6'h21, STOP); rd(6'h30);
    phase = "R9"; rd(6'h24);
    phase = "R4"; wr(6'h22, '0); rd(6'h24); wr(6'h22, '0); rd(6'h30);
    phase = "R7";
    for (int k = 0; k < 4; k++) begin
      strapPrimary = k[1]; strapSecondary = k[0]; rd(6'h08);
    end
    phase = "R5"; cyc(0, 0, 0, 0, 0, 1); rd(6'h08); cyc(0, 0, 0, 0, 1, 0); rd(6'h24);
    cyc(0, 0, 0, 0, 1, 0); rd(6'h30); cyc(0, 0, 0, 0, 1, 1);
    phase = "R3"; cyc(0, 0, 0, 0, 0, 1); wr(6'h21, '0);
    phase = "R6"; wr(6'h15, '0); wr(6'h16, '0); idle(); rd(6'h24);
    phase = "R8"; strapPrimary = 1; wr(6'h07, '1); rd(6'h07);
    strapPrimary = 0; wr(6'h07, '0); rd(6'h07); wr(6'h07, 64'h1234_5678_9ABC_DEF0); rd(6'h07);
    phase = "R10"; wr(6'h30, '1); rd(6'h30);
    cyc(1, 0, 6'h30, '1, 1, 0); rd(6'h30); wr(6'h30, '1); rd(6'h30);
    phase = "R11"; rd(6'h3F); wr(6'h01, '1); rd(6'h18); rd(6'h30); wr(6'h30, '1);
    phase = "R12"; cyc(0, 0, 0, 0, 0, 1); cyc(1, 0, 6'h21, STOP, 1, 0); rd(6'h30);
    wr(6'h18, ARM); wr(6'h21, STOP); cyc(1, 0, 6'h22, '0, 0, 1); rd(6'h30);
    cyc(1, 0, 6'h18, 64'h1, 0, 1); rd(6'h30);
    phase = "R13"; rd(6'h24); rd(6'h08); rd(6'h07); idle(); idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL %s watchdog actual=hung expected=done", phase);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule